// File: doc/BRIEF.md
# VGA Raster Timing and Screen Region Mapper

This block produces the raster timing for a 640x480 display at roughly 60 Hz. It runs entirely in the 100 MHz system clock domain, and a divide-by-four strobe sets the 25 MHz pixel rate. A horizontal counter steps once per pixel strobe. A vertical counter steps each time the horizontal counter wraps. Both sync pulses and the active-video flag are decoded from these counters.

The screen is split into two areas. The lower band is reserved for a text console. Everything above it is an image area that is stored at reduced resolution, with one buffer word for each 4x4 block of pixels. For every pixel the block reports the raw coordinates, a flag marking text-area pixels, a flag marking visible image-area pixels, and the image-buffer word address. Downstream colour storage and character logic use these outputs directly.

Top module: `vga_region_timer`

## Requirements
- R1: A synchronous reset returns both counters to 0 and the divider to phase 0. In that state `pix_en` is 0 and both sync outputs are 1. This holds whether the reset is applied at start-up or mid-frame.
- R2: `pix_en` is 1 for exactly one clock in every four. Counting clock edges k from the last reset edge, it is high after edges where k mod 4 = 3.
- R3: `px_x` advances by one on every clock edge at which `pix_en` is 1. It wraps from 799 to 0. The line is 640 active, 16 front porch, 96 sync and 48 back porch clocks.
- R4: `px_y` advances by one when `px_x` wraps. It wraps from 524 to 0. The frame is 480 active, 10 front porch, 2 sync and 33 back porch lines.
- R5: `hsync_n` is 0 exactly when 656 <= `px_x` < 752, and 1 otherwise.
- R6: `vsync_n` is 0 exactly when 490 <= `px_y` < 492, and 1 otherwise.
- R7: `active` is 1 exactly when `px_x` < 640 and `px_y` < 480.
- R8: `text_sel` is 1 exactly when `active` is 1 and `px_y` >= 400.
- R9: `img_valid` is 1 exactly when `active` is 1 and `px_y` < 400.
- R10: While `img_valid` is 1, `tile_addr` equals (`px_y`/4) shifted left by 8, plus `px_x`/4. This is the field `{px_y[8:2], px_x[9:2]}`. While `img_valid` is 0, `tile_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | output | 1 | Pixel strobe, one clock in four |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Pixel lies in the visible area |
| px_x | output | 10 | Horizontal position, blanking included |
| px_y | output | 10 | Vertical position, blanking included |
| text_sel | output | 1 | Visible pixel in the text band |
| img_valid | output | 1 | Visible pixel in the image area |
| tile_addr | output | 15 | Image-buffer word address for a 4x4 tile |

## Verification
Every clock is compared against an independent model of the strobe phase and the two counters. The comparison therefore covers the exact edges where the line and frame wrap, the first and last sync positions, and the row where the image area ends and the text band begins. An off-by-one porch or sync bound shows up as a sync pulse moved or stretched by one pixel or line. A wrong band boundary gives a row that is flagged for both areas or for neither. If the address took the wrong coordinate bits, or left stale values during blanking, `tile_addr` would disagree at tile edges or outside the visible area. A reset in mid-frame confirms that the strobe phase restarts as well as the counters.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  // True when pos lies in the half-open window [lo, lo+len).
  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // Sync output level for a given position: low inside the pulse window.
  function automatic logic sync_level(input int pos, input int active_len,
                                      input int porch, input int pulse);
    return !in_span(pos, active_len + porch, pulse);
  endfunction

endpackage

// File: rtl/vrt_pixel_div.sv
module vrt_pixel_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  // R2: the strobe never stays high on two consecutive clocks
  a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/vrt_axis_counter.sv
module vrt_axis_counter #(
  parameter int TOTAL = 800,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  logic at_last;
  assign at_last = (count == LAST);
  assign wrap    = step && at_last;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wrap) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R3/R4: no movement without a step
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
  // R3/R4: a step at the last position lands on zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> (count == '0));
endmodule

// File: rtl/vrt_region_map.sv
module vrt_region_map #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int TEXT_TOP = 400,
  parameter int X_W      = 10,
  parameter int Y_W      = 10,
  parameter int TX_W     = 8,
  parameter int TY_W     = 7
) (
  input  logic [X_W-1:0]       x,
  input  logic [Y_W-1:0]       y,
  output logic                 hsync_n,
  output logic                 vsync_n,
  output logic                 active,
  output logic                 text_sel,
  output logic                 img_valid,
  output logic [TX_W+TY_W-1:0] tile_addr
);
  import vrt_pkg::*;

  logic in_x, in_y, upper;

  always_comb begin
    in_x      = int'(x) < H_ACTIVE;
    in_y      = int'(y) < V_ACTIVE;
    upper     = int'(y) < TEXT_TOP;
    hsync_n   = sync_level(int'(x), H_ACTIVE, H_FP, H_SYNC);
    vsync_n   = sync_level(int'(y), V_ACTIVE, V_FP, V_SYNC);
    active    = in_x && in_y;
    text_sel  = active && !upper;
    img_valid = active && upper;
    tile_addr = img_valid ? {y[TY_W+1:2], x[TX_W+1:2]} : '0;
  end
endmodule

// File: rtl/vga_region_timer.sv
module vga_region_timer #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int TEXT_TOP = 400,
  parameter int PIX_DIV  = 4,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int X_W     = $clog2(H_TOTAL),
  localparam int Y_W     = $clog2(V_TOTAL),
  localparam int TX_W    = $clog2(H_ACTIVE) - 2,
  localparam int TY_W    = $clog2(TEXT_TOP) - 2,
  localparam int ADDR_W  = TX_W + TY_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              pix_en,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              active,
  output logic [X_W-1:0]    px_x,
  output logic [Y_W-1:0]    px_y,
  output logic              text_sel,
  output logic              img_valid,
  output logic [ADDR_W-1:0] tile_addr
);
  logic line_end;
  logic frame_end;

  vrt_pixel_div #(.DIV(PIX_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(pix_en)
  );

  vrt_axis_counter #(.TOTAL(H_TOTAL), .W(X_W)) u_hcnt (
    .clk(clk), .rst(rst), .step(pix_en), .count(px_x), .wrap(line_end)
  );

  vrt_axis_counter #(.TOTAL(V_TOTAL), .W(Y_W)) u_vcnt (
    .clk(clk), .rst(rst), .step(line_end), .count(px_y), .wrap(frame_end)
  );

  vrt_region_map #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC),
    .TEXT_TOP(TEXT_TOP), .X_W(X_W), .Y_W(Y_W), .TX_W(TX_W), .TY_W(TY_W)
  ) u_map (
    .x(px_x), .y(px_y), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .text_sel(text_sel), .img_valid(img_valid),
    .tile_addr(tile_addr)
  );

  // R4: the frame wraps only together with a line wrap
  a_r4_frame_in_line: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> line_end);
  // R3: a line wrap leaves x at zero on the next clock
  a_r3_line_restart: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (px_x == '0));
  // R6: the vertical pulse falls inside blanking
  a_r6_vsync_blank: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !active);
  // R5: the horizontal pulse falls inside blanking
  a_r5_hsync_blank: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !active);
  // R8/R9: a pixel belongs to at most one area
  a_r8_one_area: assert property (@(posedge clk) disable iff (rst)
    $onehot0({text_sel, img_valid}));
  // R10: no address escapes outside the image area
  a_r10_addr_idle: assert property (@(posedge clk) disable iff (rst)
    !img_valid |-> (tile_addr == '0));
endmodule

// File: tb/vga_region_timer_tb_top.sv
module vga_region_timer_tb_top;
  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 48, VF = 2, VS = 2, VB = 3;
  localparam int TT = 40;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);
  localparam int TXW = $clog2(HA) - 2;
  localparam int AW = TXW + $clog2(TT) - 2;

  typedef struct {
    int k; int h; int v;
    logic en, hs, vs, act, txt, img;
    int addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en, hsync_n, vsync_n, active, text_sel, img_valid;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  logic [AW-1:0] tile_addr;

  int total = 0;
  int bad = 0;
  int k = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  vga_region_timer #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .TEXT_TOP(TT), .PIX_DIV(4)
  ) dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .active(active), .px_x(px_x), .px_y(px_y),
    .text_sel(text_sel), .img_valid(img_valid), .tile_addr(tile_addr)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, expv, k);
    end
  endtask

  // Driver: after each edge, push the state the requirements predict.
  task automatic push_expected(input int kk);
    exp_t e;
    int p;
    p = kk / 4;
    e.k = kk;
    e.h = p % HT;
    e.v = (p / HT) % VT;
    e.en = (kk % 4) == 3;
    e.hs = !(e.h >= HA + HF && e.h < HA + HF + HS);
    e.vs = !(e.v >= VA + VF && e.v < VA + VF + VS);
    e.act = (e.h < HA) && (e.v < VA);
    e.txt = e.act && (e.v >= TT);
    e.img = e.act && (e.v < TT);
    e.addr = e.img ? ((e.v / 4) << TXW) + (e.h / 4) : 0;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst) k = 0;
    else k = k + 1;
    push_expected(k);
  end

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.k == 0) begin
        check("R1 x", int'(px_x), 0);
        check("R1 y", int'(px_y), 0);
        check("R1 pix_en", int'(pix_en), 0);
        check("R1 hsync_n", int'(hsync_n), 1);
        check("R1 vsync_n", int'(vsync_n), 1);
      end
      check("R2 pix_en", int'(pix_en), int'(e.en));
      check("R3 px_x", int'(px_x), e.h);
      check("R4 px_y", int'(px_y), e.v);
      check("R5 hsync_n", int'(hsync_n), int'(e.hs));
      check("R6 vsync_n", int'(vsync_n), int'(e.vs));
      check("R7 active", int'(active), int'(e.act));
      check("R8 text_sel", int'(text_sel), int'(e.txt));
      check("R9 img_valid", int'(img_valid), int'(e.img));
      check("R10 tile_addr", int'(tile_addr), e.addr);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // run past one full frame, then reset in mid-frame (R1)
    repeat (HT * VT * 4 + 5003) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // a further frame and a bit, covering wraps after the reset
    repeat (HT * VT * 4 + 900) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule